// File: doc/BRIEF.md
# Shared Hardware Lock Register

This block is a lock word that several processors share over a memory-mapped bus. Each processor has its own identifier. A processor claims the lock by writing its identifier and a nonzero lock value in one write. It then reads the word back. If its identifier is now in the owner field, the claim succeeded. The compare and the update happen in the same clock edge, so two competing writes can never both be accepted.

A write to the lock word takes effect only in two cases: the lock is free (value field zero), or the identifier in the write matches the stored owner. Any other write is dropped without a response. The owner releases the lock by writing its own identifier with a zero value.

A second word holds a sticky flag. Reset sets the flag, and only a write of one to bit 0 clears it. Software uses the flag to detect that a reset has happened since it last looked.

Top module: `hw_lock_reg`

## Requirements
- R1: After reset the lock word holds INIT_OWNER/INIT_VALUE (default 0, unlocked), the reset flag reads 1, and rd_valid is low.
- R2: Address 0 selects the lock word, with the owner in bits 31:16 and the lock value in bits 15:0. Address 1 selects the flag word: the flag is in bit 0, and bits 31:1 always read 0.
- R3: A read issued with rd_en in cycle N returns rdata with rd_valid high in cycle N+1. rd_valid is low in the cycle after any cycle without rd_en.
- R4: A write to address 0 while the stored value is zero replaces the whole lock word with the write data, whatever owner the write carries.
- R5: A write to address 0 whose owner bits equal the stored owner is accepted while the lock is held. This includes a release (value 0) and a change of value.
- R6: A write to address 0 while the stored value is nonzero and the owner bits differ leaves the lock word unchanged.
- R7: Writing 1 to bit 0 of address 1 clears the flag. Writing 0 to that bit leaves it unchanged. Once clear, the flag stays clear until the next reset.
- R8: When rd_en and wr_en are both high in one cycle, the read returns the contents from before that write.
- R9: A write to address 1 never changes the lock word, and a write to address 0 never changes the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Word select: 0 lock word, 1 flag word |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |

## Verification
A read and a conditional write can land on the lock word in the same cycle. The read must then report the word as it stood before the write, whether the write is accepted or not. The bench provokes this by raising rd_en and wr_en together, for an accepted owner release and for a rejected foreign claim. It checks the returned data against the pre-write contents, and then issues a second read to confirm whether the write took effect.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;
   localparam int DATA_W = 32;

   typedef enum logic {
      SEL_LOCK = 1'b0,
      SEL_FLAG = 1'b1
   } hw_lock_sel_e;
endpackage

// File: rtl/hw_lock_core.sv
module hw_lock_core #(
   parameter int OWNER_W = 16,
   parameter int VALUE_W = 16,
   parameter logic [OWNER_W-1:0] INIT_OWNER = '0,
   parameter logic [VALUE_W-1:0] INIT_VALUE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [OWNER_W-1:0] wr_owner,
   input  logic [VALUE_W-1:0] wr_value,
   output logic [OWNER_W-1:0] owner_q,
   output logic [VALUE_W-1:0] value_q
);
   logic is_free;
   logic is_owner;
   logic grant;

   // Accept the write when the lock is free or the writer already holds it.
   always_comb begin
      is_free  = (value_q == '0);
      is_owner = (wr_owner == owner_q);
      grant    = wr_en && (is_free || is_owner);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= INIT_OWNER;
         value_q <= INIT_VALUE;
      end else if (grant) begin
         owner_q <= wr_owner;
         value_q <= wr_value;
      end
   end
endmodule

// File: rtl/hw_lock_flag.sv
module hw_lock_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic flag_q
);
   // Set only by reset; a clear request is the only other event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end
endmodule

// File: rtl/hw_lock_rdport.sv
module hw_lock_rdport #(
   parameter int DATA_W     = 32,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              sel_flag,
   input  logic [DATA_W-1:0] lock_word,
   input  logic              flag,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid
);
   logic [DATA_W-1:0] mux_word;

   always_comb begin
      mux_word = sel_flag ? {{(DATA_W-1){1'b0}}, flag} : lock_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_en;
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         // Data bus keeps the last read result between reads.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= mux_word;
         end
      end else begin : g_zero
         // Data bus returns to zero when no read is in flight.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? mux_word : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/hw_lock_reg.sv
module hw_lock_reg #(
   parameter int OWNER_W = 16,
   parameter int VALUE_W = 16,
   parameter logic [OWNER_W-1:0] INIT_OWNER = '0,
   parameter logic [VALUE_W-1:0] INIT_VALUE = '0,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           addr,
   input  logic                           wr_en,
   input  logic [hw_lock_pkg::DATA_W-1:0] wdata,
   input  logic                           rd_en,
   output logic [hw_lock_pkg::DATA_W-1:0] rdata,
   output logic                           rd_valid
);
   import hw_lock_pkg::*;

   localparam int WORD_W = OWNER_W + VALUE_W;

   generate
      if (WORD_W != DATA_W) begin : g_bad_split
         $error("owner and value widths must fill the data word");
      end
      if (OWNER_W < 1 || VALUE_W < 1) begin : g_bad_width
         $error("owner and value fields need at least one bit");
      end
   endgenerate

   hw_lock_sel_e sel;
   logic         lock_wr;
   logic         flag_clr;
   logic [OWNER_W-1:0] lock_owner;
   logic [VALUE_W-1:0] lock_value;
   logic               flag_q;

   always_comb begin
      sel      = hw_lock_sel_e'(addr);
      lock_wr  = wr_en && (sel == SEL_LOCK);
      flag_clr = wr_en && (sel == SEL_FLAG) && wdata[0];
   end

   hw_lock_core #(
      .OWNER_W   (OWNER_W),
      .VALUE_W   (VALUE_W),
      .INIT_OWNER(INIT_OWNER),
      .INIT_VALUE(INIT_VALUE)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lock_wr),
      .wr_owner(wdata[DATA_W-1 -: OWNER_W]),
      .wr_value(wdata[VALUE_W-1:0]),
      .owner_q (lock_owner),
      .value_q (lock_value)
   );

   hw_lock_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flag_clr),
      .flag_q(flag_q)
   );

   hw_lock_rdport #(
      .DATA_W    (DATA_W),
      .HOLD_RDATA(HOLD_RDATA)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .sel_flag (sel == SEL_FLAG),
      .lock_word({lock_owner, lock_value}),
      .flag     (flag_q),
      .rdata    (rdata),
      .rd_valid (rd_valid)
   );
endmodule

// File: rtl/hw_lock_sva.sv
module hw_lock_sva #(
   parameter int OWNER_W = 16,
   parameter int VALUE_W = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       addr,
   input logic                       wr_en,
   input logic [OWNER_W+VALUE_W-1:0] wdata,
   input logic                       rd_en,
   input logic [OWNER_W+VALUE_W-1:0] rdata,
   input logic                       rd_valid,
   input logic [OWNER_W-1:0]         lock_owner,
   input logic [VALUE_W-1:0]         lock_value,
   input logic                       flag_q
);
   localparam int W = OWNER_W + VALUE_W;

   AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R3
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R3
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr) |=> (rdata[W-1:1] == '0)); // R2
   AST_FREE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && lock_value == '0)
      |=> ({lock_owner, lock_value} == $past(wdata))); // R4
   AST_OWNER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[W-1 -: OWNER_W] == lock_owner)
      |=> ({lock_owner, lock_value} == $past(wdata))); // R5
   AST_FOREIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && lock_value != '0 && wdata[W-1 -: OWNER_W] != lock_owner)
      |=> $stable({lock_owner, lock_value})); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q |=> !flag_q); // R7
   AST_LOCK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !addr) |=> $stable({lock_owner, lock_value})); // R9
   AST_FLAG_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr) |=> $stable(flag_q)); // R9
endmodule

bind hw_lock_reg hw_lock_sva #(
   .OWNER_W(OWNER_W),
   .VALUE_W(VALUE_W)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wr_en     (wr_en),
   .wdata     (wdata),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .rd_valid  (rd_valid),
   .lock_owner(lock_owner),
   .lock_value(lock_value),
   .flag_q    (flag_q)
);

// File: tb/hw_lock_reg_test.sv
module hw_lock_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic        rd_valid;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   hw_lock_reg uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid)
   );

   // {is_write, addr, data, expected read, requirement number}
   localparam int NV = 19;
   localparam logic [69:0] VEC [NV] = '{
      {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 4'd1}, // R1 unlocked at start
      {1'b1, 1'b0, 32'h0005_0001, 32'h0,         4'd4}, // id 5 claims
      {1'b0, 1'b0, 32'h0,         32'h0005_0001, 4'd4}, // R4
      {1'b1, 1'b0, 32'h0007_0001, 32'h0,         4'd6}, // id 7 contends
      {1'b0, 1'b0, 32'h0,         32'h0005_0001, 4'd6}, // R6
      {1'b1, 1'b0, 32'h0005_0003, 32'h0,         4'd5}, // owner changes value
      {1'b0, 1'b0, 32'h0,         32'h0005_0003, 4'd5}, // R5
      {1'b1, 1'b0, 32'h0005_0000, 32'h0,         4'd5}, // owner releases
      {1'b0, 1'b0, 32'h0,         32'h0005_0000, 4'd5}, // R5
      {1'b1, 1'b0, 32'h0007_0002, 32'h0,         4'd4}, // id 7 takes free lock
      {1'b0, 1'b0, 32'h0,         32'h0007_0002, 4'd4}, // R4
      {1'b0, 1'b1, 32'h0,         32'h0000_0001, 4'd2}, // R2 flag set, reserved 0
      {1'b1, 1'b1, 32'h0000_0000, 32'h0,         4'd7}, // write 0
      {1'b0, 1'b1, 32'h0,         32'h0000_0001, 4'd7}, // R7 unchanged
      {1'b1, 1'b1, 32'hFFFF_FFFE, 32'h0,         4'd7}, // bit0 zero
      {1'b0, 1'b1, 32'h0,         32'h0000_0001, 4'd7}, // R7 unchanged
      {1'b1, 1'b1, 32'h0000_0001, 32'h0,         4'd7}, // clear
      {1'b0, 1'b1, 32'h0,         32'h0000_0000, 4'd7}, // R7 cleared
      {1'b0, 1'b0, 32'h0,         32'h0007_0002, 4'd9}  // R9 lock untouched
   };

   function automatic string rname(input int n);
      case (n)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Read: rd_en sampled at one edge, result checked at the next negedge.
   task automatic rd(input logic a, input logic [31:0] exp, input string req);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(req, {31'b0, rd_valid}, 32'd1);
      check(req, rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {31'b0, rd_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", {31'b0, rd_valid}, 32'd0); // R3 idle
      rd(1'b1, 32'h1, "R1");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][69]) wr(VEC[i][68], VEC[i][67:36]);
         else rd(VEC[i][68], VEC[i][35:4], rname(int'(VEC[i][3:0])));
      end

      // R3: no read -> rd_valid low the next cycle
      @(negedge clk);
      check("R3", {31'b0, rd_valid}, 32'd0);

      // R8: rejected foreign write with simultaneous read
      @(negedge clk);
      addr = 1'b0; wdata = 32'h0009_0004; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R8", rdata, 32'h0007_0002);
      rd(1'b0, 32'h0007_0002, "R6");

      // R8: accepted release with simultaneous read
      @(negedge clk);
      addr = 1'b0; wdata = 32'h0007_0000; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R8", rdata, 32'h0007_0002);
      rd(1'b0, 32'h0007_0000, "R8");

      // R9: lock write does not touch flag; R7 flag stays clear
      wr(1'b0, 32'h0003_0001);
      rd(1'b1, 32'h0, "R9");
      rd(1'b0, 32'h0003_0001, "R4");
      wr(1'b1, 32'h0000_0001);
      rd(1'b1, 32'h0, "R7");
      // R9: flag write does not touch lock
      rd(1'b0, 32'h0003_0001, "R9");

      // R1: reset mid-run restores initial state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", {31'b0, rd_valid}, 32'd0);
      rst_n = 1'b1;
      rd(1'b0, 32'h0, "R1");
      rd(1'b1, 32'h1, "R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule